// File: doc/BRIEF.md
# Auto-Reload PWM Timer

This block is a 12-bit up-counter that restarts from a programmable start value each time it passes its top state. It drives one PWM output from that count. Each period begins in the start state. The output rises when the counter leaves the start state and falls when the counter leaves the active duty state. The duty value is double-buffered. Software writes a preload copy, and that copy becomes active only at an overflow, and only while the transfer bit is set. This lets software change the duty every period without producing a broken pulse.

Software reaches the block through a byte-wide write port. The start value is written as two bytes, and it is committed as one 12-bit word only when the high byte arrives. An overflow therefore never picks up a half-written value. A clock-select field picks the counting rate, and a change to it applies on the next clock. The `tick_i` input stands in for a prescaled count clock. The overflow and compare flags are sticky and are cleared by writing 1 to them.

Top module: `arpwm_timer`

## Requirements
- R1: When a count step happens in state 0xFFF, the counter loads the start value; in any other state it adds one. A period is therefore 4096 minus the start value steps.
- R2: The overflow flag is set by the step from 0xFFF to the start value.
- R3: The PWM level drops to 0 at the end of the step in which the count equals the active duty value, unless that value is 0xFFF.
- R4: The PWM level rises to 1 at the end of the step in which the count equals the start value. If the duty value equals the start value, the drop wins and the duty is 0%.
- R5: A duty write reaches only the preload copy. The preload copy moves to the active copy at an overflow when the transfer bit (control bit 2) is 1. When that bit is 0, the active copy keeps its value.
- R6: The compare flag is set by any step in which the count equals the active duty value.
- R7: The clock select (control bits 1:0) applies from the next clock. Code 00 stops the counter, 01 steps it on every clock, and 10 or 11 step it on clocks where `tick_i` is 1.
- R8: A duty value of 0xFFF keeps the output high for the whole period once it has risen.
- R9: `pwm_o` equals the PWM level gated by the output-enable bit (control bit 3), and `pwm_oe_o` shows that bit.
- R10: Address 0 (start value low byte) only fills a holding byte. Address 1 (high byte, bits 3:0) commits the full 12-bit start value. Addresses 2 and 3 write the low and high parts of the duty preload, address 4 is the control register, and address 5 clears flags.
- R11: Writing 1 to bit 0 (overflow) or bit 1 (compare) at address 5 clears that flag. A set in the same cycle wins over the clear.
- R12: After reset, the counter, the flags, the PWM level, the start value, the duty copies and the control bits are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable used by clock select 10/11 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| pwm_o | output | 1 | PWM pin, gated by output enable |
| pwm_oe_o | output | 1 | Output-enable state of the PWM pin |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky compare-match flag |

## Verification
A wrong internal count or a wrong start value shows up as a wrong period: the gap between two overflow flags changes from the first period after the fault. A wrong active duty copy, or a transfer at the wrong moment, changes the number of high cycles in the very next period. A bad flag or output-enable state appears on the pins in the cycle after the write or event that caused it. A reference model in the bench follows every clock, so any divergence is reported within one cycle.

// File: rtl/arpwm_pkg.sv
package arpwm_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] A_REL_LO  = 3'd0;
  localparam logic [ADDR_W-1:0] A_REL_HI  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DUTY_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_DUTY_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 3'd5;

  // control bit positions
  localparam int CTRL_TRAN = 2;
  localparam int CTRL_OE   = 3;

  localparam logic [1:0] CS_OFF  = 2'b00;
  localparam logic [1:0] CS_FULL = 2'b01;

  // count step decision from clock select and prescaled tick
  function automatic logic step_ok(input logic [1:0] cs, input logic tick);
    return (cs == CS_FULL) || (cs[1] && tick);
  endfunction
endpackage

// File: rtl/arpwm_counter.sv
module arpwm_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_evt_o,
  output logic             rel_evt_o,
  output logic             match_evt_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] rel);
    return (c == TOP) ? rel : c + 1'b1;
  endfunction

  assign ovf_evt_o   = step_i && (count_q == TOP);
  assign rel_evt_o   = step_i && (count_q == reload_i);
  assign match_evt_o = step_i && (count_q == duty_i);
  assign count_o     = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (step_i) count_q <= next_count(count_q, reload_i);
  end

  // R2: overflow lands on the start value
  p_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_o |=> (count_q == $past(reload_i)));
  // R1: ordinary step adds one
  p_count_up_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && count_q != TOP) |=> (count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/arpwm_regs.sv
module arpwm_regs
  import arpwm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ovf_evt_i,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  duty_o,
  output logic [1:0]        cs_o,
  output logic              oe_o,
  output logic              clr_ovf_o,
  output logic              clr_cmp_o
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] rel_lo_q;
  logic [CNT_W-1:0]  reload_q, duty_pre_q, duty_sh_q;
  logic [1:0]        cs_q;
  logic              tran_q, oe_q;
  logic              unused_bits;

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return wr_en_i && (wr_addr_i == a);
  endfunction

  assign unused_bits = ^wr_data_i[DATA_W-1:HI_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_lo_q   <= '0;
      reload_q   <= '0;
      duty_pre_q <= '0;
      duty_sh_q  <= '0;
      cs_q       <= CS_OFF;
      tran_q     <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      if (hit(A_REL_LO))  rel_lo_q <= wr_data_i;
      if (hit(A_REL_HI))  reload_q <= {wr_data_i[HI_W-1:0], rel_lo_q};
      if (hit(A_DUTY_LO)) duty_pre_q[DATA_W-1:0] <= wr_data_i;
      if (hit(A_DUTY_HI)) duty_pre_q[CNT_W-1:DATA_W] <= wr_data_i[HI_W-1:0];
      if (hit(A_CTRL)) begin
        cs_q   <= wr_data_i[1:0];
        tran_q <= wr_data_i[CTRL_TRAN];
        oe_q   <= wr_data_i[CTRL_OE];
      end
      if (ovf_evt_i && tran_q) duty_sh_q <= duty_pre_q;
    end
  end

  assign reload_o  = reload_q;
  assign duty_o    = duty_sh_q;
  assign cs_o      = cs_q;
  assign oe_o      = oe_q;
  assign clr_ovf_o = hit(A_FLAGS) && wr_data_i[0];
  assign clr_cmp_o = hit(A_FLAGS) && wr_data_i[1];

  // R10: low byte alone never moves the committed start value
  p_lo_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit(A_REL_LO) |=> $stable(reload_q));
  // R5: active duty changes only on overflow with transfer set
  p_shadow_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_evt_i && tran_q) |=> $stable(duty_sh_q));
endmodule

// File: rtl/arpwm_out.sv
module arpwm_out #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ovf_evt_i,
  input  logic             rel_evt_i,
  input  logic             match_evt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             oe_i,
  input  logic             clr_ovf_i,
  input  logic             clr_cmp_i,
  output logic             pwm_o,
  output logic             ovf_flag_o,
  output logic             cmp_flag_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic pwm_q, ovf_q, cmp_q;
  logic fall_evt;

  // set-priority sticky flag update
  function automatic logic sticky(input logic cur, input logic set, input logic clr);
    return set || (cur && !clr);
  endfunction

  assign fall_evt = match_evt_i && (duty_i != FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
      ovf_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      if (fall_evt)       pwm_q <= 1'b0;
      else if (rel_evt_i) pwm_q <= 1'b1;
      ovf_q <= sticky(ovf_q, ovf_evt_i, clr_ovf_i);
      cmp_q <= sticky(cmp_q, match_evt_i, clr_cmp_i);
    end
  end

  assign pwm_o      = pwm_q && oe_i;
  assign ovf_flag_o = ovf_q;
  assign cmp_flag_o = cmp_q;

  // R11: an overflow always leaves the flag set
  p_ovf_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> ovf_q);
  // R6: a compare always leaves the flag set
  p_cmp_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_evt_i |=> cmp_q);
  // R8: full duty never drops a high output
  p_full_duty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == FULL && pwm_q) |=> pwm_q);
endmodule

// File: rtl/arpwm_timer.sv
module arpwm_timer
  import arpwm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pwm_o,
  output logic              pwm_oe_o,
  output logic              ovf_flag_o,
  output logic              cmp_flag_o
);
  logic [CNT_W-1:0] reload, duty_sh, count;
  logic [1:0]       cs;
  logic             oe, clr_ovf, clr_cmp;
  logic             step, ovf_evt, rel_evt, match_evt;

  assign step     = step_ok(cs, tick_i);
  assign pwm_oe_o = oe;

  arpwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ovf_evt_i(ovf_evt), .reload_o(reload), .duty_o(duty_sh),
    .cs_o(cs), .oe_o(oe), .clr_ovf_o(clr_ovf), .clr_cmp_o(clr_cmp)
  );

  arpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .step_i(step), .reload_i(reload), .duty_i(duty_sh),
    .count_o(count), .ovf_evt_o(ovf_evt), .rel_evt_o(rel_evt),
    .match_evt_o(match_evt)
  );

  arpwm_out #(.CNT_W(CNT_W)) u_out (
    .clk_i, .rst_ni, .ovf_evt_i(ovf_evt), .rel_evt_i(rel_evt),
    .match_evt_i(match_evt), .duty_i(duty_sh), .oe_i(oe),
    .clr_ovf_i(clr_ovf), .clr_cmp_i(clr_cmp), .pwm_o(pwm_o),
    .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o)
  );

  // R7: stopped clock select freezes the count
  p_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs == CS_OFF) |=> $stable(count));
endmodule

// File: tb/test_arpwm_timer.sv
module test_arpwm_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] TOPV = 12'hFFF;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, tick_run = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic pwm_o, pwm_oe_o, ovf_flag_o, cmp_flag_o;
  int n_chk = 0, n_fail = 0;
  logic mon_en = 1'b0;

  arpwm_timer i_arpwm_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pwm_o(pwm_o),
    .pwm_oe_o(pwm_oe_o), .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) tick <= tick_run ? ~tick : 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model written from the requirements
  logic [11:0] m_cnt, m_rel, m_pre, m_sh;
  logic [7:0]  m_lo;
  logic [1:0]  m_cs;
  logic        m_tran, m_oe, m_pwm, m_ovf, m_cmp;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_rel <= 0; m_pre <= 0; m_sh <= 0; m_lo <= 0; m_cs <= 0;
      m_tran <= 0; m_oe <= 0; m_pwm <= 0; m_ovf <= 0; m_cmp <= 0;
    end else begin
      logic st, ov, eq, clro, clrc;
      st = (m_cs == 2'b01) || (m_cs[1] && tick);
      ov = st && m_cnt == TOPV;
      eq = st && m_cnt == m_sh;
      clro = wr_en && wr_addr == 3'd5 && wr_data[0];
      clrc = wr_en && wr_addr == 3'd5 && wr_data[1];
      if (st) m_cnt <= ov ? m_rel : m_cnt + 1;
      if (ov && m_tran) m_sh <= m_pre;
      if (eq && m_sh != TOPV) m_pwm <= 0;
      else if (st && m_cnt == m_rel) m_pwm <= 1;
      m_ovf <= ov | (m_ovf & ~clro);
      m_cmp <= eq | (m_cmp & ~clrc);
      if (wr_en) case (wr_addr)
        3'd0: m_lo <= wr_data;
        3'd1: m_rel <= {wr_data[3:0], m_lo};
        3'd2: m_pre[7:0] <= wr_data;
        3'd3: m_pre[11:8] <= wr_data[3:0];
        3'd4: begin m_cs <= wr_data[1:0]; m_tran <= wr_data[2]; m_oe <= wr_data[3]; end
        default: ;
      endcase
    end
  end

  always @(negedge clk) if (mon_en) begin
    chk("R3/R4 model pwm_o", int'(pwm_o), int'(m_pwm & m_oe));
    chk("R9 model pwm_oe_o", int'(pwm_oe_o), int'(m_oe));
    chk("R2 model ovf_flag", int'(ovf_flag_o), int'(m_ovf));
    chk("R6 model cmp_flag", int'(cmp_flag_o), int'(m_cmp));
  end

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_reload(input logic [11:0] v);
    wr(3'd0, v[7:0]); wr(3'd1, {4'h0, v[11:8]});
  endtask

  task automatic set_duty(input logic [11:0] v);
    wr(3'd2, v[7:0]); wr(3'd3, {4'h0, v[11:8]});
  endtask

  task automatic period(output int n);
    wr(3'd5, 8'h01);
    while (!ovf_flag_o) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0; n = 1;
    while (!ovf_flag_o) begin @(negedge clk); n++; end
  endtask

  task automatic high_cnt(input int len, output int h);
    h = 0;
    repeat (len) begin @(negedge clk); if (pwm_o) h++; end
  endtask

  task automatic t_reset;
    chk("R12 pwm after reset", int'(pwm_o), 0);
    chk("R12 ovf after reset", int'(ovf_flag_o), 0);
    chk("R12 cmp after reset", int'(cmp_flag_o), 0);
    chk("R12 oe after reset", int'(pwm_oe_o), 0);
    repeat (20) @(negedge clk);
    chk("R7 code 00 holds counter after reset", int'(ovf_flag_o), 0);
  endtask

  task automatic t_period;
    int n;
    set_reload(12'hFF0);
    wr(3'd4, 8'h01);
    period(n); chk("R1 period of start 0xFF0", n, 16);
    wr(3'd0, 8'hE0);
    period(n); period(n); chk("R10 low byte alone keeps period", n, 16);
    wr(3'd1, 8'h0F);
    period(n); period(n); chk("R10 high byte commits 0xFE0", n, 32);
    set_reload(12'hFF0);
    period(n); period(n); chk("R1 back to 16", n, 16);
  endtask

  task automatic t_duty;
    int n, h;
    set_duty(12'hFF8);
    wr(3'd4, 8'h0D);                      // cs=01, transfer, output enable
    period(n); period(n);
    high_cnt(16, h); chk("R3 duty 0xFF8 high cycles", h, 8);
    wr(3'd4, 8'h09);                      // transfer off
    set_duty(12'hFF4);
    period(n); period(n);
    high_cnt(16, h); chk("R5 transfer off keeps old duty", h, 8);
    wr(3'd4, 8'h0D);
    period(n); period(n);
    high_cnt(16, h); chk("R5 transfer on applies 0xFF4", h, 4);
    set_duty(12'hFFF);
    period(n); period(n);
    high_cnt(16, h); chk("R8 duty 0xFFF full high", h, 16);
    wr(3'd5, 8'h02); @(negedge clk);
    chk("R11 compare flag cleared", int'(cmp_flag_o), 0);
    period(n);
    chk("R6 compare flag at state 0xFFF", int'(cmp_flag_o), 1);
    set_duty(12'hFF0);
    period(n); period(n);
    high_cnt(16, h); chk("R4 duty equal start gives 0%", h, 0);
    set_duty(12'hFF8);
    wr(3'd4, 8'h05);                      // output disabled
    period(n); period(n);
    high_cnt(16, h); chk("R9 gated output stays low", h, 0);
    chk("R9 oe pin shows bit", int'(pwm_oe_o), 0);
    wr(3'd4, 8'h0D);
    chk("R9 oe pin set", int'(pwm_oe_o), 1);
  endtask

  task automatic t_setwins;
    int n;
    period(n);
    repeat (15) @(negedge clk);
    wr(3'd5, 8'h01);
    chk("R11 set wins over clear", int'(ovf_flag_o), 1);
    wr(3'd5, 8'h01);
    chk("R11 clear without set", int'(ovf_flag_o), 0);
  endtask

  task automatic t_clksel;
    int n;
    tick_run = 1'b1;
    wr(3'd4, 8'h0E);
    period(n); period(n); chk("R7 code 10 on tick", n, 32);
    wr(3'd4, 8'h0F);
    period(n); period(n); chk("R7 code 11 on tick", n, 32);
    wr(3'd4, 8'h0C);
    wr(3'd5, 8'h03);
    repeat (40) @(negedge clk);
    chk("R7 code 00 stops overflow", int'(ovf_flag_o), 0);
    chk("R7 code 00 stops compare", int'(cmp_flag_o), 0);
    tick_run = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    t_reset;
    t_period;
    t_duty;
    t_setwins;
    t_clksel;
    mon_en = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule